// File: doc/BRIEF.md
# Floating-Point Status Flag Updater

This block owns a 32-bit floating-point status register and folds the raw exception flags of one arithmetic or conversion operation into it. The flags are a raw invalid flag with three sub-causes, overflow, underflow and inexact. The update sets sticky bits and summary bits. It may rewrite the fraction-inexact bit and the result-class field, depending on two per-instruction controls. When an enabled cause is present, it raises a deferred program-exception request with an encoded cause.

The request comes out as a registered one-cycle pulse, one cycle after the update is presented. It therefore trails the commit of the operation's result and can be taken as a deferred trap. Software rewrites the register, and clears its sticky bits, through a write port that takes priority over any update in the same cycle. Instruction groups that must not disturb the fraction-inexact bit or the class field keep the matching control low. Compares and min/max keep both low. Round-to-integer and conversions to integer raise only the fraction-inexact control.

Top module: `fpsu_top`

## Requirements
- R1: After reset the status register reads 0, `exc_req_o` is 0 and `exc_cause_o` is 0.
- R2: On an update with `fl_invalid` high, each of the three sub-causes sets its own sticky bit: times-zero bit 20, infinity-difference bit 21, signalling NaN bit 22. Any such hit also sets the invalid summary (bit 29) and the exception summary (bit 31). Several sub-causes may land in one update. Sub-causes presented with `fl_invalid` low change nothing.
- R3: Overflow and underflow are handled independently in the same update. Overflow sets bit 28 and bit 31. Underflow sets bit 27 and bit 31.
- R4: Inexact sets sticky bit 26 and bit 31. It sets the fraction-inexact bit 17 only while `ctl_fi` is high.
- R5: With `ctl_fi` high and no inexact flag, bit 17 is cleared. With `ctl_fi` low, bit 17 is left unchanged.
- R6: A times-zero or infinity-difference hit with `ctl_class` high writes bits [16:12] = 5'b10001 (class bit 16 set, unordered code 4'b0001 in [15:12]). A signalling-NaN hit alone never alters bits [16:12].
- R7: An update whose causes include one enabled by its enable input (`en_inv` covers all invalid sub-causes) produces `exc_req_o` high for exactly the next cycle. In that same cycle bit 30, the enabled-exception summary, reads set. With no enabled cause there is no request and bit 30 is not set.
- R8: `exc_cause_o` is {4'h1, code} while a request is signalled and 0 otherwise. The codes are times-zero 1, infinity-difference 2, signalling NaN 3, overflow 4, underflow 5 and inexact 6. When several enabled causes coincide, the highest code is reported.
- R9: Updates only ever set the sticky bits (20, 21, 22, 26, 27, 28, 29, 30, 31). Those bits are cleared only by a software write.
- R10: When `sw_we` is high, the register takes `sw_data` on the next edge and no request is made, whatever the update inputs carry.
- R11: With `upd_valid` and `sw_we` both low, the register holds and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | An operation's flags are presented this cycle |
| fl_invalid | input | 1 | Raw invalid-operation flag |
| fl_imz | input | 1 | Invalid sub-cause: infinity times zero |
| fl_isi | input | 1 | Invalid sub-cause: infinity minus infinity |
| fl_snan | input | 1 | Invalid sub-cause: signalling NaN operand |
| fl_ovf | input | 1 | Overflow flag |
| fl_unf | input | 1 | Underflow flag |
| fl_inx | input | 1 | Inexact flag |
| en_inv | input | 1 | Trap enable for invalid operations |
| en_ovf | input | 1 | Trap enable for overflow |
| en_unf | input | 1 | Trap enable for underflow |
| en_inx | input | 1 | Trap enable for inexact |
| ctl_fi | input | 1 | Instruction may change the fraction-inexact bit |
| ctl_class | input | 1 | Instruction may overwrite the result-class field |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write value |
| stat_o | output | 32 | Current status register |
| exc_req_o | output | 1 | Deferred program-exception request pulse |
| exc_cause_o | output | 8 | Encoded cause, valid with the request |

## Verification
The hardest case to reach is an update in which several enabled causes coincide. All three invalid sub-causes, overflow, underflow and inexact must be present at once, so that the cause priority, the class rewrite and the single enabled-summary set are checked together. Random stimulus that draws each flag independently almost never lines these up. Directed cases therefore assert all flags with every enable on, then remove the top-priority causes one by one. A second hard case is a software write that lands in the same cycle as a fully loaded update. It is forced directly, and random steps also mix in rare writes between updates.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

    localparam int STAT_W   = 32;
    localparam int NUM_INV  = 3;
    localparam int NUM_SRC  = NUM_INV + 3;
    localparam int CODE_W   = 4;
    localparam int CAUSE_W  = 2 * CODE_W;
    localparam int COND_W   = 4;

    localparam int B_ANY    = 31;
    localparam int B_ENS    = 30;
    localparam int B_INVS   = 29;
    localparam int B_OVF    = 28;
    localparam int B_UNF    = 27;
    localparam int B_INX    = 26;
    localparam int B_SUB0   = 20;
    localparam int B_FRI    = 17;
    localparam int B_CLS    = 16;
    localparam int B_COND   = 12;

    localparam logic [CODE_W-1:0] FP_GROUP  = 4'h1;
    localparam logic [COND_W-1:0] COND_UNORD = 4'b0001;

    typedef enum logic [CODE_W-1:0] {
        CZ_NONE = 4'd0,
        CZ_IMZ  = 4'd1,
        CZ_ISI  = 4'd2,
        CZ_SNAN = 4'd3,
        CZ_OVF  = 4'd4,
        CZ_UNF  = 4'd5,
        CZ_INX  = 4'd6
    } cause_code_e;

    typedef struct packed {
        logic [STAT_W-1:0]  stat;
        logic               req;
        logic [CAUSE_W-1:0] cause;
    } upd_state_t;

endpackage

// File: rtl/fpsu_invalid.sv
module fpsu_invalid
    import fpsu_pkg::*;
#(
    parameter int NSUB = NUM_INV,
    parameter logic [NSUB-1:0] CLASS_MASK = 3'b011
) (
    input  logic            inv_flag,
    input  logic [NSUB-1:0] sub_in,
    input  logic            ctl_class,
    output logic [NSUB-1:0] sub_hit,
    output logic            any_hit,
    output logic            class_wr
);

    genvar gi;
    for (gi = 0; gi < NSUB; gi++) begin : g_sub
        assign sub_hit[gi] = inv_flag & sub_in[gi];
    end

    assign any_hit  = |sub_hit;
    assign class_wr = ctl_class & (|(sub_hit & CLASS_MASK));

endmodule

// File: rtl/fpsu_fi.sv
module fpsu_fi (
    input  logic inx_flag,
    input  logic ctl_fi,
    input  logic fi_cur,
    output logic fi_next
);

    always_comb begin
        fi_next = fi_cur;
        if (ctl_fi) begin
            fi_next = inx_flag;
        end
    end

endmodule

// File: rtl/fpsu_cause.sv
module fpsu_cause
    import fpsu_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic [NSRC-1:0]   src_hit,
    input  logic [NSRC-1:0]   src_en,
    output logic              req,
    output logic [CODE_W-1:0] code
);

    logic [NSRC-1:0] armed;
    assign armed = src_hit & src_en;

    always_comb begin
        code = CZ_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (armed[i]) begin
                code = CODE_W'(i + 1);
            end
        end
    end

    assign req = |armed;

endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
    import fpsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic               fl_invalid,
    input  logic               fl_imz,
    input  logic               fl_isi,
    input  logic               fl_snan,
    input  logic               fl_ovf,
    input  logic               fl_unf,
    input  logic               fl_inx,
    input  logic               en_inv,
    input  logic               en_ovf,
    input  logic               en_unf,
    input  logic               en_inx,
    input  logic               ctl_fi,
    input  logic               ctl_class,
    input  logic               sw_we,
    input  logic [STAT_W-1:0]  sw_data,
    output logic [STAT_W-1:0]  stat_o,
    output logic               exc_req_o,
    output logic [CAUSE_W-1:0] exc_cause_o
);

    upd_state_t st_d, st_q;

    logic [NUM_INV-1:0] inv_hit;
    logic               inv_any;
    logic               cls_wr;
    logic               fi_nx;
    logic [NUM_SRC-1:0] src_hit;
    logic [NUM_SRC-1:0] src_en;
    logic               cz_req;
    logic [CODE_W-1:0]  cz_code;

    fpsu_invalid #(.NSUB(NUM_INV)) u_inv (
        .inv_flag  (fl_invalid),
        .sub_in    ({fl_snan, fl_isi, fl_imz}),
        .ctl_class (ctl_class),
        .sub_hit   (inv_hit),
        .any_hit   (inv_any),
        .class_wr  (cls_wr)
    );

    fpsu_fi u_fi (
        .inx_flag (fl_inx),
        .ctl_fi   (ctl_fi),
        .fi_cur   (st_q.stat[B_FRI]),
        .fi_next  (fi_nx)
    );

    // processing order: invalid sub-causes, overflow, underflow, inexact
    assign src_hit = {fl_inx, fl_unf, fl_ovf, inv_hit};
    assign src_en  = {en_inx, en_unf, en_ovf, {NUM_INV{en_inv}}};

    fpsu_cause #(.NSRC(NUM_SRC)) u_cause (
        .src_hit (src_hit),
        .src_en  (src_en),
        .req     (cz_req),
        .code    (cz_code)
    );

    always_comb begin
        st_d       = st_q;
        st_d.req   = 1'b0;
        st_d.cause = '0;
        if (sw_we) begin
            st_d.stat = sw_data;
        end else if (upd_valid) begin
            for (int i = 0; i < NUM_INV; i++) begin
                if (inv_hit[i]) begin
                    st_d.stat[B_SUB0 + i] = 1'b1;
                end
            end
            if (inv_any) begin
                st_d.stat[B_INVS] = 1'b1;
                st_d.stat[B_ANY]  = 1'b1;
            end
            if (cls_wr) begin
                st_d.stat[B_COND +: COND_W] = COND_UNORD;
                st_d.stat[B_CLS]            = 1'b1;
            end
            if (fl_ovf) begin
                st_d.stat[B_OVF] = 1'b1;
                st_d.stat[B_ANY] = 1'b1;
            end
            if (fl_unf) begin
                st_d.stat[B_UNF] = 1'b1;
                st_d.stat[B_ANY] = 1'b1;
            end
            if (fl_inx) begin
                st_d.stat[B_INX] = 1'b1;
                st_d.stat[B_ANY] = 1'b1;
            end
            st_d.stat[B_FRI] = fi_nx;
            if (cz_req) begin
                st_d.stat[B_ENS] = 1'b1;
                st_d.req         = 1'b1;
                st_d.cause       = {FP_GROUP, cz_code};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o      = st_q.stat;
    assign exc_req_o   = st_q.req;
    assign exc_cause_o = st_q.cause;

endmodule

// File: rtl/fpsu_checker.sv
module fpsu_checker
    import fpsu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic               fl_invalid,
    input logic               fl_imz,
    input logic               fl_isi,
    input logic               ctl_fi,
    input logic               ctl_class,
    input logic               sw_we,
    input logic [STAT_W-1:0]  sw_data,
    input logic [STAT_W-1:0]  stat_o,
    input logic               exc_req_o,
    input logic [CAUSE_W-1:0] exc_cause_o
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[B_OVF] && !sw_we) |=> stat_o[B_OVF]); // R9

    AST_ANY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[B_ANY] && !sw_we) |=> stat_o[B_ANY]); // R9

    AST_REQ_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid || sw_we) |=> !exc_req_o); // R7

    AST_REQ_ENS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> stat_o[B_ENS]); // R7

    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req_o |-> (exc_cause_o == '0)); // R8

    AST_CAUSE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (exc_cause_o[CAUSE_W-1:CODE_W] == FP_GROUP)); // R8

    AST_FI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_fi && !sw_we) |=> $stable(stat_o[B_FRI])); // R5

    AST_CLASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !(upd_valid && fl_invalid && (fl_imz || fl_isi) && ctl_class))
        |=> $stable(stat_o[B_CLS:B_COND])); // R6

    AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (stat_o == $past(sw_data))); // R10

endmodule

bind fpsu_top fpsu_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_valid   (upd_valid),
    .fl_invalid  (fl_invalid),
    .fl_imz      (fl_imz),
    .fl_isi      (fl_isi),
    .ctl_fi      (ctl_fi),
    .ctl_class   (ctl_class),
    .sw_we       (sw_we),
    .sw_data     (sw_data),
    .stat_o      (stat_o),
    .exc_req_o   (exc_req_o),
    .exc_cause_o (exc_cause_o)
);

// File: tb/fpsu_top_test.sv
module fpsu_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid, fl_invalid, fl_imz, fl_isi, fl_snan;
    logic        fl_ovf, fl_unf, fl_inx;
    logic        en_inv, en_ovf, en_unf, en_inx, ctl_fi, ctl_class, sw_we;
    logic [31:0] sw_data;
    logic [31:0] stat_o;
    logic        exc_req_o;
    logic [7:0]  exc_cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] m_stat = '0;

    always #5 clk = ~clk;

    fpsu_top uut (.*);

    task automatic clr_in();
        {upd_valid, fl_invalid, fl_imz, fl_isi, fl_snan, fl_ovf, fl_unf, fl_inx} = '0;
        {en_inv, en_ovf, en_unf, en_inx, ctl_fi, ctl_class, sw_we} = '0;
        sw_data = '0;
    endtask

    // model from the requirements: {stat, req, cause}
    function automatic logic [40:0] ref_next(logic [31:0] s);
        logic [31:0] n;
        logic [3:0]  code;
        if (sw_we) return {sw_data, 1'b0, 8'h00};
        if (!upd_valid) return {s, 1'b0, 8'h00};
        n = s;
        code = 4'd0;
        if (fl_invalid) begin
            if (fl_imz)  begin n[20] = 1'b1; n[29] = 1'b1; n[31] = 1'b1; if (en_inv) code = 4'd1; end
            if (fl_isi)  begin n[21] = 1'b1; n[29] = 1'b1; n[31] = 1'b1; if (en_inv) code = 4'd2; end
            if (fl_snan) begin n[22] = 1'b1; n[29] = 1'b1; n[31] = 1'b1; if (en_inv) code = 4'd3; end
            if ((fl_imz || fl_isi) && ctl_class) n[16:12] = 5'b10001;
        end
        if (fl_ovf) begin n[28] = 1'b1; n[31] = 1'b1; if (en_ovf) code = 4'd4; end
        if (fl_unf) begin n[27] = 1'b1; n[31] = 1'b1; if (en_unf) code = 4'd5; end
        if (fl_inx) begin n[26] = 1'b1; n[31] = 1'b1; if (en_inx) code = 4'd6; end
        if (ctl_fi) n[17] = fl_inx;
        if (code != 4'd0) begin
            n[30] = 1'b1;
            return {n, 1'b1, 4'h1, code};
        end
        return {n, 1'b0, 8'h00};
    endfunction

    task automatic check(string tag, logic [40:0] act, logic [40:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stat/req/cause actual %h/%b/%h expected %h/%b/%h",
                     tag, act[40:9], act[8], act[7:0], exp[40:9], exp[8], exp[7:0]);
        end
    endtask

    // inputs already set at a negedge; clock once, sample at next negedge
    task automatic step(string tag);
        logic [40:0] e;
        e = ref_next(m_stat);
        @(posedge clk);
        @(negedge clk);
        check(tag, {stat_o, exc_req_o, exc_cause_o}, e);
        m_stat = e[40:9];
        clr_in();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clr_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {stat_o, exc_req_o, exc_cause_o}, 41'd0);

        // R2 R6 R8: all invalid sub-causes, enabled, class write
        upd_valid = 1; fl_invalid = 1; fl_imz = 1; fl_isi = 1; fl_snan = 1;
        en_inv = 1; ctl_class = 1;
        step("R2 all subs");
        check("R6 class code", {stat_o[16:12], 36'd0}, {5'b10001, 36'd0});
        check("R8 snan cause", {33'd0, exc_cause_o}, {33'd0, 8'h13});

        // R11 idle cycle
        step("R11 idle");

        // R9 clear by software, then R2 subs without invalid flag ignored
        sw_we = 1; sw_data = 32'h0;
        step("R10 clear");
        upd_valid = 1; fl_imz = 1; fl_isi = 1; fl_snan = 1; en_inv = 1; ctl_class = 1;
        step("R2 subs ignored w/o invalid");
        check("R2 still zero", {stat_o, 9'd0}, 41'd0);

        // R6 snan alone with class control
        upd_valid = 1; fl_invalid = 1; fl_snan = 1; ctl_class = 1;
        step("R6 snan no class");
        check("R6 class untouched", {stat_o[16:12], 36'd0}, 41'd0);

        // R3 ovf + unf together, disabled => R7 no request
        upd_valid = 1; fl_ovf = 1; fl_unf = 1;
        step("R3 ovf+unf");
        check("R7 no req", {40'd0, exc_req_o}, 41'd0);

        // R4 / R5 fraction-inexact control
        sw_we = 1; sw_data = 32'h0;
        step("R10 clear2");
        upd_valid = 1; fl_inx = 1;
        step("R4 inx no fi");
        upd_valid = 1; fl_inx = 1; ctl_fi = 1;
        step("R4 inx fi");
        check("R4 fi set", {40'd0, stat_o[17]}, 41'd1);
        upd_valid = 1; ctl_fi = 0;
        step("R5 fi hold");
        upd_valid = 1; ctl_fi = 1;
        step("R5 fi clear");
        check("R5 fi clear val", {40'd0, stat_o[17]}, 41'd0);

        // R8 priority
        upd_valid = 1; fl_invalid = 1; fl_imz = 1; fl_isi = 1; fl_snan = 1;
        fl_ovf = 1; fl_unf = 1; fl_inx = 1;
        en_inv = 1; en_ovf = 1; en_unf = 1; en_inx = 1;
        step("R8 all enabled");
        check("R8 top cause", {33'd0, exc_cause_o}, {33'd0, 8'h16});
        upd_valid = 1; fl_invalid = 1; fl_snan = 1; fl_ovf = 1; fl_unf = 1;
        en_inv = 1; en_ovf = 1;
        step("R8 ovf over snan");
        check("R8 ovf code", {33'd0, exc_cause_o}, {33'd0, 8'h14});

        // R10 software write colliding with update
        upd_valid = 1; fl_invalid = 1; fl_imz = 1; fl_ovf = 1; fl_inx = 1;
        en_inv = 1; en_ovf = 1; en_inx = 1; ctl_fi = 1; ctl_class = 1;
        sw_we = 1; sw_data = 32'h0000_A5A5;
        step("R10 sw wins");

        // R9 sticky bits hold across flag-free updates
        sw_we = 1; sw_data = 32'hFC70_0000;
        step("R9 load");
        upd_valid = 1; ctl_fi = 1; ctl_class = 1;
        step("R9 hold");
        check("R9 sticky kept", {stat_o & 32'hFC70_0000, 9'd0}, {32'hFC70_0000, 9'd0});

        // random mix
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED_1234);
        end
        for (int k = 0; k < 4000; k++) begin
            upd_valid  = ($urandom_range(3) != 0);
            fl_invalid = ($urandom_range(2) == 0);
            fl_imz     = ($urandom_range(3) == 0);
            fl_isi     = ($urandom_range(3) == 0);
            fl_snan    = ($urandom_range(3) == 0);
            fl_ovf     = ($urandom_range(4) == 0);
            fl_unf     = ($urandom_range(4) == 0);
            fl_inx     = ($urandom_range(2) == 0);
            en_inv     = $urandom_range(1);
            en_ovf     = $urandom_range(1);
            en_unf     = $urandom_range(1);
            en_inx     = $urandom_range(1);
            ctl_fi     = $urandom_range(1);
            ctl_class  = $urandom_range(1);
            sw_we      = ($urandom_range(15) == 0);
            sw_data    = $urandom();
            step("R2..R11 random (R7 R8 R9)");
        end

        finish_run();
    end

endmodule